// File: doc/BRIEF.md
# Truncated Exponential Backoff Engine

This block schedules retransmission after collisions for every transmit port of a switch. Each collision on the frame in flight raises a per-frame attempt count. The engine then draws a random wait from a free-running LFSR. The wait is a whole number of slot times, and its range doubles with each attempt until a cap is reached. The engine counts slot ticks until the wait has elapsed and then issues a one-cycle retry pulse that lets the port send the frame again.

One strictness setting governs every port. The setting can come from a board pin or from a global configuration bit, and a build parameter chooses which. With strictness high, the engine follows the standard limit: when the sixteenth attempt also collides, it raises a one-cycle drop pulse and the frame is abandoned. With strictness low, the engine never gives up. The count wraps to zero, the backoff sequence starts again from the smallest range, and the frame is retried at once. A successful transmission clears the count and cancels any pending wait in one cycle, so the port can start its next frame within the inter-frame gap.

Top module: `bo_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `retry_go_o` and `drop_o` are 0 and `attempts_o` is 0.
- R2: A collision accepted while idle, and that is not the sixteenth in a row, makes `attempts_o` show n in the next cycle, where n is the number of collisions since the last clear.
- R3: After the n-th collision the engine waits r slot ticks, with r in 0 .. 2^min(n,10) − 1. `busy_o` is high during the wait. `retry_go_o` pulses for one cycle in the cycle after the r-th tick, or in the cycle after the collision when r is 0.
- R4: Slot ticks while idle have no effect. During a wait, `busy_o` stays high and no retry is issued unless a tick arrives.
- R5: With strictness high (1), the sixteenth consecutive collision gives a one-cycle `drop_o` pulse in the next cycle, with `attempts_o` at 0 and no retry pulse and no wait.
- R6: With strictness low (0), the sixteenth consecutive collision sets `attempts_o` to 0 and gives `retry_go_o` in the next cycle with no wait. The following collision counts as attempt 1 again.
- R7: `tx_ok_i` clears `attempts_o` and any pending wait in the next cycle, without a retry pulse. It takes priority over a collision in the same cycle.
- R8: A collision that arrives while `busy_o` is high is ignored, and `attempts_o` and the wait stay as they were.
- R9: With the default parameter LIMIT_FROM_PIN = 1, strictness is taken from `strict_pin_i` and `strict_cfg_i` has no effect. With the parameter at 0, `strict_cfg_i` is used.
- R10: The wait comes from a free-running, never-zero LFSR, so repeated draws at the same attempt range do not all give the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coll_i | input | 1 | Collision seen on the current attempt (one-cycle pulse) |
| tx_ok_i | input | 1 | Frame sent without collision (one-cycle pulse) |
| slot_tick_i | input | 1 | One pulse per elapsed slot time |
| strict_pin_i | input | 1 | Strictness from the board pin |
| strict_cfg_i | input | 1 | Strictness from the global configuration bit |
| busy_o | output | 1 | Backoff wait in progress |
| retry_go_o | output | 1 | One-cycle pulse: retransmission may start |
| drop_o | output | 1 | One-cycle pulse: frame abandoned after too many collisions |
| attempts_o | output | 5 | Consecutive collisions for the current frame |

## Verification
The assertions check several rules on every cycle. A last tick ends the wait with a retry pulse, and a wait without ticks holds. The count steps by one on an ordinary collision and never reaches sixteen. A success clears everything. Collisions during a wait leave the count unchanged, a drop and a retry never coincide, and the LFSR never reaches zero. The bench scenarios cover what a single cycle cannot show. These are the full sixteen-attempt runs in both strictness settings, the source selection between pin and configuration bit, whether each measured wait falls inside the doubling range, and whether the draws vary across attempts.

// File: rtl/bo_pkg.sv
package bo_pkg;

  // Outcome of an accepted collision, decided by the attempt counter
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_STEP = 2'd1,
    EV_DROP = 2'd2,
    EV_WRAP = 2'd3
  } coll_event_e;

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
  parameter int            WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'h1D2B
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIDTH-1:0] state_o
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  // Galois form: shift right, fold the taps in when a one leaves
  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

  p_lfsr_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    state_q != '0)
    else $error("p_lfsr_nonzero_r10: LFSR locked at zero");

endmodule

// File: rtl/bo_attempt_counter.sv
module bo_attempt_counter
  import bo_pkg::*;
#(
  parameter int ATTEMPT_LIMIT = 16,
  parameter int CNT_W         = $clog2(ATTEMPT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             accept_i,
  input  logic             strict_i,
  output coll_event_e      event_o,
  output logic [CNT_W-1:0] next_o,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  assign next_o = count_q + CNT_W'(1);

  always_comb begin
    event_o = EV_NONE;
    if (accept_i) begin
      if (next_o == CNT_W'(ATTEMPT_LIMIT)) event_o = strict_i ? EV_DROP : EV_WRAP;
      else                                 event_o = EV_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      count_q <= '0;
    end else begin
      case (event_o)
        EV_STEP: count_q <= next_o;
        EV_DROP,
        EV_WRAP: count_q <= '0;
        default: count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (event_o == EV_STEP && !clear_i) |=> count_q == $past(count_q) + CNT_W'(1))
    else $error("p_count_step_r2: count did not advance");

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count_q < CNT_W'(ATTEMPT_LIMIT))
    else $error("p_count_bound_r5: count reached the limit");

  p_count_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> count_q == '0)
    else $error("p_count_clear_r7: success did not clear count");

endmodule

// File: rtl/bo_slot_timer.sv
module bo_slot_timer #(
  parameter int VAL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic             load_i,
  input  logic [VAL_W-1:0] val_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             done_o
);

  logic [VAL_W-1:0] remain_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      remain_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        remain_q <= val_i;
        if (val_i == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q && tick_i) begin
        remain_q <= remain_q - VAL_W'(1);
        if (remain_q == VAL_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_last_tick_go_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tick_i && !abort_i && remain_q == VAL_W'(1)) |=> (done_q && !busy_q))
    else $error("p_last_tick_go_r3: wait end missed");

  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick_i && !abort_i) |=> (busy_q && !done_q))
    else $error("p_hold_no_tick_r4: wait left without tick");

  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!busy_q && !done_q))
    else $error("p_abort_r7: abort left wait running");

endmodule

// File: rtl/bo_engine.sv
module bo_engine
  import bo_pkg::*;
#(
  parameter int          ATTEMPT_LIMIT  = 16,
  parameter int          BACKOFF_CAP    = 10,
  parameter int          LFSR_W         = 16,
  parameter logic [15:0] LFSR_TAPS      = 16'hB400,
  parameter logic [15:0] LFSR_SEED      = 16'h1D2B,
  parameter bit          LIMIT_FROM_PIN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coll_i,
  input  logic       tx_ok_i,
  input  logic       slot_tick_i,
  input  logic       strict_pin_i,
  input  logic       strict_cfg_i,
  output logic       busy_o,
  output logic       retry_go_o,
  output logic       drop_o,
  output logic [4:0] attempts_o
);

  localparam int CNT_W  = $clog2(ATTEMPT_LIMIT + 1);
  localparam int RAND_W = BACKOFF_CAP;

  logic              strict;
  logic              accept;
  logic              busy;
  logic              done;
  logic              drop_q;
  coll_event_e       ev;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nxt;
  logic [LFSR_W-1:0] rnd;
  logic [RAND_W-1:0] mask;
  logic [RAND_W-1:0] draw;
  logic              load;
  logic [RAND_W-1:0] load_val;

  // Strictness source picked at build time
  generate
    if (LIMIT_FROM_PIN) begin : g_pin
      assign strict = strict_pin_i;
    end else begin : g_cfg
      assign strict = strict_cfg_i;
    end
  endgenerate

  assign accept = coll_i & ~busy & ~tx_ok_i;

  bo_lfsr #(
    .WIDTH (LFSR_W),
    .TAPS  (LFSR_W'(LFSR_TAPS)),
    .SEED  (LFSR_W'(LFSR_SEED))
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .state_o (rnd)
  );

  bo_attempt_counter #(
    .ATTEMPT_LIMIT (ATTEMPT_LIMIT),
    .CNT_W         (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (tx_ok_i),
    .accept_i (accept),
    .strict_i (strict),
    .event_o  (ev),
    .next_o   (nxt),
    .count_o  (cnt)
  );

  // Range mask: the low min(n, cap) bits are open
  always_comb begin
    for (int i = 0; i < RAND_W; i++) begin
      mask[i] = (int'(nxt) > i);
    end
  end

  assign draw     = rnd[RAND_W-1:0] & mask;
  assign load     = (ev == EV_STEP) || (ev == EV_WRAP);
  assign load_val = (ev == EV_WRAP) ? '0 : draw;

  bo_slot_timer #(
    .VAL_W (RAND_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .abort_i (tx_ok_i),
    .load_i  (load),
    .val_i   (load_val),
    .tick_i  (slot_tick_i),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk) begin
    if (rst) drop_q <= 1'b0;
    else     drop_q <= (ev == EV_DROP) && !tx_ok_i;
  end

  assign busy_o     = busy;
  assign retry_go_o = done;
  assign drop_o     = drop_q;
  assign attempts_o = 5'(cnt);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (coll_i && busy_o && !tx_ok_i) |=> $stable(attempts_o))
    else $error("p_busy_ignore_r8: collision during wait counted");

  p_go_drop_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(retry_go_o && drop_o))
    else $error("p_go_drop_excl_r6: retry and drop together");

  p_drop_state_r5: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> (attempts_o == 5'd0 && !busy_o))
    else $error("p_drop_state_r5: drop with live state");

  p_drop_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    drop_o |=> !drop_o)
    else $error("p_drop_pulse_r5: drop longer than one cycle");

endmodule

// File: tb/bo_engine_bench.sv
module bo_engine_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coll_i = 1'b0, tx_ok_i = 1'b0, slot_tick_i = 1'b0;
  logic       strict_pin_i = 1'b1, strict_cfg_i = 1'b0;
  logic       busy_o, retry_go_o, drop_o;
  logic [4:0] attempts_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bo_engine u_bo_engine (
    .clk(clk), .rst(rst), .coll_i(coll_i), .tx_ok_i(tx_ok_i),
    .slot_tick_i(slot_tick_i), .strict_pin_i(strict_pin_i),
    .strict_cfg_i(strict_cfg_i), .busy_o(busy_o), .retry_go_o(retry_go_o),
    .drop_o(drop_o), .attempts_o(attempts_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int range_max(input int n);
    int k = (n > 10) ? 10 : n;
    return (1 << k) - 1;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Clear state through the success input
  task automatic clear_frame();
    @(negedge clk); tx_ok_i = 1'b1;
    @(negedge clk); tx_ok_i = 1'b0;
  endtask

  // One collision with continuous slot ticks; returns measured wait
  task automatic attempt(input int n, output int w);
    @(negedge clk); coll_i = 1'b1; slot_tick_i = 1'b1;
    @(negedge clk); coll_i = 1'b0;
    check(attempts_o == 5'(n), "R2 count after collision", attempts_o, n);
    w = 0;
    while (!retry_go_o) begin
      check(busy_o == 1'b1, "R3 busy during wait", busy_o, 1);
      @(negedge clk); w++;
      if (w > 2000) break;
    end
    check(w <= range_max(n), "R3 wait inside range", w, range_max(n));
    @(negedge clk);
    check(retry_go_o == 1'b0, "R3 retry is one cycle", retry_go_o, 0);
    slot_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy_o && !retry_go_o && !drop_o, "R1 flags in reset", {busy_o, retry_go_o, drop_o}, 0);
    check(attempts_o == 0, "R1 count in reset", attempts_o, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !retry_go_o && !drop_o && attempts_o == 0, "R1 after reset",
          {busy_o, retry_go_o, drop_o}, 0);
  endtask

  task automatic t_idle_ticks();
    slot_tick_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!busy_o && !retry_go_o && attempts_o == 0, "R4 idle tick no effect",
            {busy_o, retry_go_o}, 0);
    end
    slot_tick_i = 1'b0;
  endtask

  task automatic t_strict_limit();
    int w;
    int first_w;
    bit varied;
    strict_pin_i = 1'b1; strict_cfg_i = 1'b0;
    clear_frame();
    varied = 1'b0; first_w = -1;
    for (int n = 1; n < 16; n++) begin
      attempt(n, w);
      if (n >= 10) begin
        if (first_w < 0) first_w = w;
        else if (w != first_w) varied = 1'b1;
      end
    end
    check(varied, "R10 draws vary at cap range", varied, 1);
    @(negedge clk); coll_i = 1'b1;
    @(negedge clk); coll_i = 1'b0;
    check(drop_o == 1'b1, "R5 drop on sixteenth", drop_o, 1);
    check(attempts_o == 0 && !busy_o && !retry_go_o, "R5 state at drop", attempts_o, 0);
    @(negedge clk);
    check(drop_o == 1'b0 && !retry_go_o, "R5 drop one cycle, no retry", drop_o, 0);
  endtask

  task automatic t_wrap_limit();
    int w;
    strict_pin_i = 1'b0; strict_cfg_i = 1'b1;   // R9: cfg must be ignored
    clear_frame();
    for (int n = 1; n < 16; n++) attempt(n, w);
    @(negedge clk); coll_i = 1'b1;
    @(negedge clk); coll_i = 1'b0;
    check(retry_go_o == 1'b1 && drop_o == 1'b0, "R6 R9 immediate retry on wrap", retry_go_o, 1);
    check(attempts_o == 0 && !busy_o, "R6 count wraps to zero", attempts_o, 0);
    attempt(1, w);
    check(w <= 1, "R6 restart at smallest range", w, 1);
  endtask

  task automatic t_abort_ignore();
    bit got_busy;
    clear_frame();
    slot_tick_i = 1'b0; got_busy = 1'b0;
    for (int i = 0; i < 12 && !got_busy; i++) begin
      @(negedge clk); coll_i = 1'b1;
      @(negedge clk); coll_i = 1'b0;
      if (busy_o) got_busy = 1'b1;
    end
    check(got_busy, "R3 some draw gives a wait", got_busy, 1);
    begin
      automatic int held = attempts_o;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(busy_o && !retry_go_o, "R4 wait holds without tick", busy_o, 1);
      end
      @(negedge clk); coll_i = 1'b1;
      @(negedge clk); coll_i = 1'b0;
      check(attempts_o == 5'(held) && busy_o, "R8 collision in wait ignored", attempts_o, held);
    end
    @(negedge clk); coll_i = 1'b1; tx_ok_i = 1'b1;
    @(negedge clk); coll_i = 1'b0; tx_ok_i = 1'b0;
    check(attempts_o == 0 && !busy_o && !retry_go_o, "R7 success wins and clears", attempts_o, 0);
    slot_tick_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!retry_go_o && !busy_o, "R7 no retry after abort", retry_go_o, 0);
    end
    slot_tick_i = 1'b0;
    @(negedge clk); coll_i = 1'b1;
    @(negedge clk); coll_i = 1'b0;
    check(attempts_o == 1, "R7 next frame starts fresh", attempts_o, 1);
    clear_frame();
  endtask

  initial begin
    t_reset();
    t_idle_ticks();
    t_strict_limit();
    t_wrap_limit();
    t_abort_ignore();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
    finish_run();
  end

endmodule